// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

The block is a chain of identical 4-bit binary up-counting stages. All state bits are clocked on one rising edge, so every output bit moves in the same cycle. Each stage takes a shared active-low synchronous clear, a shared active-low synchronous parallel load, a shared parallel enable and its own trickle enable. Each stage also produces a terminal-count carry. Inside the chain, the carry of one stage drives the trickle enable of the next stage. The chain therefore counts as one wide synchronous binary counter with no gating beyond the stages themselves.

A per-stage hold input forces the trickle enable of a chosen stage low. This lets a link of the chain be broken on purpose. Shorter count lengths come from decoding the desired last value of `q` into `clear_n` outside the block. Because the clear is synchronous, it lands on the edge after the decode.

Top module: `count_chain`

## Requirements
- R1: When `clear_n` is 0 at a rising edge of `clk`, every bit of `q` is 0 after that edge, whatever the values of `load_n`, `enp`, `ent` and `stage_hold`. Clear wins over load.
- R2: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `data` after that edge, whatever the enables are.
- R3: With `clear_n` and `load_n` both 1, a stage whose parallel enable and trickle enable are both 1 at the edge advances by one. A stage at 15 wraps to 0, so the whole chain wraps from all ones to zero.
- R4: With `clear_n` and `load_n` both 1, a stage whose parallel enable or trickle enable is 0 at the edge keeps its value.
- R5: `rco` is combinational. It is 1 exactly when the last stage holds 15 and its trickle enable is 1. `enp` never affects it.
- R6: Stage 0 takes `ent` as its trickle enable. Stage k>0 takes the carry of stage k-1. All stages share `enp`. With no hold set, `q` counts as a single binary counter of 4*STAGES bits.
- R7: `stage_hold[k]`=1 forces the trickle enable of stage k to 0. That stage then holds its value, its carry is 0, and every stage above it holds as well.
- R8: Stage k loads `data[4k+3:4k]` and drives `q[4k+3:4k]`. Stage 0 is the least significant nibble.
- R9: Driving `clear_n` low while `q` equals M-1, and high otherwise, makes the chain count 0..M-1 repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Parallel count enable shared by all stages |
| ent | input | 1 | Trickle count enable of stage 0 |
| stage_hold | input | STAGES | Per-stage force of the trickle enable to 0 |
| data | input | 4*STAGES | Parallel load value, nibble k for stage k |
| q | output | 4*STAGES | Count value, nibble k from stage k |
| rco | output | 1 | Terminal-count carry of the last stage |

## Verification
The bench builds the chain with STAGES=3, which gives a 12-bit counter with a true middle stage. With that build, a hold on stage 1 can be checked for its effect both below and above the break. The 4096-state wrap of the full width can be walked in a few thousand cycles. A behavioural integer model is compared with `q` and `rco` on every clock. The stimulus covers priority clashes, carries across both nibble boundaries, the `enp` insensitivity of `rco`, and a modulo-10 sequence formed by feeding the decoded count back into `clear_n`.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Priority: clear, then load, then count (both enables), else hold.
  function automatic cnt_op_e pick_op(input logic clear_n, input logic load_n,
                                      input logic enp, input logic ent);
    if (!clear_n) return OP_CLEAR;
    if (!load_n) return OP_LOAD;
    if (enp && ent) return OP_COUNT;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    enp,
  input  logic    ent,
  output cnt_op_e op
);
  assign op = pick_op(clear_n, load_n, enp, ent);
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         ent,
  output logic         at_max,
  output logic         rco
);
  function automatic logic is_all_ones(input logic [W-1:0] v);
    return &v;
  endfunction

  assign at_max = is_all_ones(q);
  assign rco    = at_max & ent;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] data,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  cnt_op_e      op;
  logic [W-1:0] q_next;
  logic         at_max;

  cnt_ctrl u_ctrl (
    .clear_n(clear_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .op     (op)
  );

  always_comb begin
    case (op)
      OP_CLEAR: q_next = '0;
      OP_LOAD:  q_next = data;
      OP_COUNT: q_next = advance(q);
      default:  q_next = q;
    endcase
  end

  always_ff @(posedge clk) q <= q_next;

  cnt_carry #(.W(W)) u_carry (
    .q     (q),
    .ent   (ent),
    .at_max(at_max),
    .rco   (rco)
  );

  // The state is unknown until the first clear or load defines it.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clear_n || !load_n) primed <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk) !clear_n |=> q == '0);
  assert_load_R2: assert property (@(posedge clk) clear_n && !load_n |=> q == $past(data));
  assert_count_R3: assert property (@(posedge clk) disable iff (!primed)
    clear_n && load_n && enp && ent && !at_max |=> q == $past(q) + ONE);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!primed)
    clear_n && load_n && enp && ent && at_max |=> q == '0);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
    clear_n && load_n && !(enp && ent) |=> $stable(q));
  assert_rco_R5: assert property (@(posedge clk) disable iff (!primed)
    rco |-> (ent && q == '1));
endmodule

// File: rtl/count_chain.sv
module count_chain #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic                  clk,
  input  logic                  clear_n,
  input  logic                  load_n,
  input  logic                  enp,
  input  logic                  ent,
  input  logic [STAGES-1:0]     stage_hold,
  input  logic [STAGES*W-1:0]   data,
  output logic [STAGES*W-1:0]   q,
  output logic                  rco
);
  localparam int TW = STAGES * W;

  logic [STAGES-1:0] ent_v;
  logic [STAGES-1:0] rco_v;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign ent_v[k] = ent & ~stage_hold[k];
    end else begin : g_link
      assign ent_v[k] = rco_v[k-1] & ~stage_hold[k];
    end

    cnt_stage #(.W(W)) u_stage (
      .clk    (clk),
      .clear_n(clear_n),
      .load_n (load_n),
      .enp    (enp),
      .ent    (ent_v[k]),
      .data   (data[k*W +: W]),
      .q      (q[k*W +: W]),
      .rco    (rco_v[k])
    );
  end

  assign rco = rco_v[STAGES-1];

  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clear_n || !load_n) primed <= 1'b1;

  assert_chain_step_R6: assert property (@(posedge clk) disable iff (!primed)
    clear_n && load_n && enp && ent && stage_hold == '0 |=> q == TW'($past(q) + 1'b1));

  for (genvar k = 0; k < STAGES; k++) begin : g_hold_chk
    assert_hold_R7: assert property (@(posedge clk) disable iff (!primed)
      clear_n && load_n && stage_hold[k] |=> $stable(q[k*W +: W]));
    assert_hold_carry_R7: assert property (@(posedge clk) disable iff (!primed)
      stage_hold[k] |-> !rco_v[k]);
  end
endmodule

// File: tb/tb_count_chain.sv
`timescale 1ns/1ps
module tb_count_chain;
  localparam int STAGES = 3;
  localparam int W      = 4;
  localparam int TW     = STAGES * W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              clear_n = 1'b1;
  logic              load_n  = 1'b1;
  logic              enp     = 1'b0;
  logic              ent     = 1'b0;
  logic [STAGES-1:0] stage_hold = '0;
  logic [TW-1:0]     data = '0;
  logic [TW-1:0]     q;
  logic              rco;

  count_chain #(.STAGES(STAGES), .W(W)) dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enp(enp), .ent(ent),
    .stage_hold(stage_hold), .data(data), .q(q), .rco(rco)
  );

  int checks = 0;
  int errors = 0;
  int ref_q  = 0;
  bit known  = 1'b0;
  bit done   = 1'b0;

  function automatic int nib(input int v, input int k);
    return (v >> (4 * k)) & 15;
  endfunction

  // Trickle enable seen by stage k in the reference.
  function automatic bit stage_ent(input int k);
    bit e = ent && !stage_hold[0];
    for (int j = 0; j < k; j++) e = e && (nib(ref_q, j) == 15) && !stage_hold[j+1];
    return e;
  endfunction

  function automatic bit exp_rco();
    return (nib(ref_q, STAGES-1) == 15) && stage_ent(STAGES-1);
  endfunction

  task automatic model_edge();
    int nxt = 0;
    for (int k = 0; k < STAGES; k++) begin
      int n = nib(ref_q, k);
      bit en = stage_ent(k);
      if (!clear_n) n = 0;
      else if (!load_n) n = (int'(data) >> (4 * k)) & 15;
      else if (enp && en) n = (n + 1) & 15;
      nxt = nxt | (n << (4 * k));
    end
    ref_q = nxt;
    if (!clear_n || !load_n) known = 1'b1;
  endtask

  task automatic check_rco(input string tag);
    if (!known) return;
    checks++;
    if (rco !== exp_rco()) begin
      errors++;
      $display("FAIL %s rco: actual %b expected %b (q=%h)", tag, rco, exp_rco(), q);
    end
  endtask

  task automatic check_q(input string tag);
    if (!known) return;
    checks++;
    if (q !== TW'(ref_q)) begin
      errors++;
      $display("FAIL %s q: actual %h expected %h", tag, q, TW'(ref_q));
    end
  endtask

  // Called at a falling edge: drive, check combinational carry, clock, check state.
  task automatic step(input bit cl, input bit ld, input bit p, input bit t,
                      input logic [STAGES-1:0] h, input int d, input string tag);
    clear_n = cl; load_n = ld; enp = p; ent = t; stage_hold = h; data = TW'(d);
    #1;
    check_rco(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_q(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: clear beats load and enables
    step(0, 0, 1, 1, '0, 'h5A5, "R1");
    // R2, R8: load with enables low, nibbles land in place
    step(1, 0, 0, 0, '0, 'hABC, "R2_R8");
    step(1, 0, 1, 1, 3'b111, 'h123, "R2_R8");
    // R3: counting, including a nibble carry
    step(1, 0, 0, 0, '0, 'h0FD, "R3");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, '0, 0, "R3");
    // R4: either enable low holds
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, '0, 0, "R4");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, '0, 0, "R4");
    // R3 wrap of the whole chain, R6 carry across both boundaries
    step(1, 0, 0, 0, '0, 'hFFD, "R3");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, '0, 0, "R3_R6");
    // R5: rco at max with enp low, then with ent low
    step(1, 0, 0, 0, '0, 'hFFF, "R5");
    step(1, 1, 0, 1, '0, 0, "R5");
    step(1, 1, 1, 0, '0, 0, "R5");
    step(1, 1, 0, 1, '0, 0, "R5");
    // R7: hold on the middle stage while the low nibble overflows
    step(1, 0, 0, 0, '0, 'h3FD, "R7");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 3'b010, 0, "R7");
    step(1, 0, 0, 0, '0, 'hFFE, "R7");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 3'b010, 0, "R7");
    step(1, 0, 0, 0, '0, 'h0EE, "R7");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 3'b001, 0, "R7");
    // R9: modulo-10 via decoded clear
    step(0, 1, 0, 0, '0, 0, "R9");
    for (int i = 0; i < 32; i++) step((ref_q != 9), 1, 1, 1, '0, 0, "R9");
    // R6: full-width walk through every value and back to zero
    step(0, 1, 0, 0, '0, 0, "R6");
    for (int i = 0; i < 4097; i++) step(1, 1, 1, 1, '0, 0, "R6");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule